// File: doc/BRIEF.md
# Offset and gain calibration corrector

This block sits between a conversion filter and the data register that software reads. Each valid filter result is corrected using one of three calibration pairs, picked by a channel index. A pair holds a signed offset and an unsigned gain. The block first subtracts the offset from the raw result. It then multiplies the difference by the gain and clamps the product to the 24-bit signed range. The corrected word appears two clock cycles after the raw word.

The same pairs can be loaded in two ways. The first is a simple register port: a write strobe, a register select code and a channel index. The second is capture at the end of a calibration. A calibration mode code with a valid sample stores that sample in the offset of the selected pair. It can instead store a precomputed gain word, taken from a dedicated input, in the gain of the selected pair. Calibration samples produce no corrected output.

Top module: `calCorrector`

## Requirements
- R1: After reset, every offset register reads 24'h000000, every gain register reads 24'h800000, and outValid is 0.
- R2: With regWrEn high, regSel 3'b101 writes regWrData to the offset register of pair chanSel, and regSel 3'b110 writes it to the gain register. regRdData shows that register's current content combinationally. No other pair changes.
- R3: A regSel code other than 3'b101 or 3'b110 writes nothing and reads 0.
- R4: A conversion sample has inValid high and modeCode[2] low. For such a sample, outData = floor((inData − offset) × gain / 2^23). inData and the offset are two's complement. The gain is unsigned, with 23 fractional bits. The subtraction is applied before the scaling.
- R5: A result above 24'h7FFFFF is clamped to 24'h7FFFFF. A result below −2^23 is clamped to 24'h800000.
- R6: outValid is high exactly two cycles after each conversion sample and low otherwise. outData holds its value while outValid is low.
- R7: A valid sample with modeCode 3'b100 or 3'b110 stores inData into the offset of pair chanSel and produces no output. This capture takes priority over a register write to the same register in the same cycle.
- R8: A valid sample with modeCode 3'b101 or 3'b111 stores gainCalIn into the gain of pair chanSel and produces no output. This capture takes priority over a register write to the same register in the same cycle.
- R9: chanSel 3 selects no pair. Writes and captures are ignored, reads return 0, and a conversion passes inData through unchanged (offset 0, unity gain).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Raw sample valid |
| inData | input | 24 | Raw signed filter result |
| modeCode | input | 3 | Operating mode; bit 2 set means calibration, bit 0 picks gain over offset |
| chanSel | input | 2 | Pair index for samples and register access |
| gainCalIn | input | 24 | Gain word stored by a gain calibration |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 3 | Register select code |
| regWrData | input | 24 | Register write data |
| regRdData | output | 24 | Register read data |
| outValid | output | 1 | Corrected result valid |
| outData | output | 24 | Corrected signed result |

## Verification
Random samples with random offsets and gains across full range cover the ordinary correction path. Directed patterns separate specific faults:
- A half gain with a nonzero offset distinguishes subtract-then-scale from scale-then-subtract.
- Extreme inputs against extreme offsets drive both clamp limits.
- Zero gain and unity gain expose errors in fractional alignment.
- Calibration samples mixed with writes to the same register show the capture priority and that no output is emitted.
- Channel 3 traffic shows the pass-through and ignored-access behaviour.

// File: rtl/calPkg.sv
package calPkg;
  parameter int CAL_DW    = 24;
  parameter int CAL_PAIRS = 3;
  localparam int CAL_CHW  = $clog2(CAL_PAIRS + 1);

  localparam logic [2:0] SEL_OFFSET = 3'b101;
  localparam logic [2:0] SEL_GAIN   = 3'b110;

  typedef struct packed {
    logic [CAL_PAIRS-1:0] offLoad;
    logic [CAL_PAIRS-1:0] gainLoad;
    logic                 offFromCal;
    logic                 gainFromCal;
    logic                 convStart;
    logic                 pairHit;
    logic                 rdOff;
    logic                 rdGain;
    logic [CAL_CHW-1:0]   pairIdx;
  } calStrobes_t;
endpackage

// File: rtl/calCtrl.sv
module calCtrl
  import calPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [2:0]         modeCode,
  input  logic [CAL_CHW-1:0] chanSel,
  input  logic               regWrEn,
  input  logic [2:0]         regSel,
  output calStrobes_t        st
);
  logic pairHit, calSample, offCal, gainCal, offWr, gainWr;

  always_comb begin
    pairHit   = (chanSel < CAL_CHW'(CAL_PAIRS));
    calSample = inValid && modeCode[2];
    offCal    = calSample && !modeCode[0];
    gainCal   = calSample && modeCode[0];
    offWr     = regWrEn && (regSel == SEL_OFFSET);
    gainWr    = regWrEn && (regSel == SEL_GAIN);
  end

  for (genvar k = 0; k < CAL_PAIRS; k++) begin : g_dec
    logic hitK;
    assign hitK = pairHit && (chanSel == CAL_CHW'(k));
    assign st.offLoad[k]  = hitK && (offCal || offWr);
    assign st.gainLoad[k] = hitK && (gainCal || gainWr);
  end

  assign st.offFromCal  = offCal;
  assign st.gainFromCal = gainCal;
  assign st.convStart   = inValid && !modeCode[2];
  assign st.pairHit     = pairHit;
  assign st.rdOff       = pairHit && (regSel == SEL_OFFSET);
  assign st.rdGain      = pairHit && (regSel == SEL_GAIN);
  assign st.pairIdx     = chanSel;

  // R2: at most one pair loads per register kind
  p_one_pair_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(st.offLoad) && $onehot0(st.gainLoad));
  // R7/R8: calibration samples never start a conversion
  p_cal_no_conv_r7: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && modeCode[2]) |-> !st.convStart);
  // R9: channel 3 touches no pair
  p_no_pair_load_r9: assert property (@(posedge clk) disable iff (!rstN)
    (chanSel >= CAL_CHW'(CAL_PAIRS)) |-> (st.offLoad == '0 && st.gainLoad == '0));
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calPkg::*;
#(
  parameter int DW   = CAL_DW,
  parameter int FRAC = CAL_DW - 1
) (
  input  logic          clk,
  input  logic          rstN,
  input  calStrobes_t   st,
  input  logic [DW-1:0] inData,
  input  logic [DW-1:0] gainCalIn,
  input  logic [DW-1:0] regWrData,
  output logic [DW-1:0] regRdData,
  output logic          outValid,
  output logic [DW-1:0] outData
);
  localparam int PW = 2 * DW + 2;
  localparam logic [DW-1:0] UNITY = DW'(1) << FRAC;
  localparam logic signed [PW-1:0] MAXV = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] MINV = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  logic [DW-1:0] offReg  [CAL_PAIRS];
  logic [DW-1:0] gainReg [CAL_PAIRS];

  for (genvar k = 0; k < CAL_PAIRS; k++) begin : g_pair
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        offReg[k]  <= '0;
        gainReg[k] <= UNITY;
      end else begin
        if (st.offLoad[k])
          offReg[k] <= st.offFromCal ? inData : regWrData;
        if (st.gainLoad[k])
          gainReg[k] <= st.gainFromCal ? gainCalIn : regWrData;
      end
    end

    // R7: offset calibration captures the raw sample
    p_off_capture_r7: assert property (@(posedge clk) disable iff (!rstN)
      (st.offLoad[k] && st.offFromCal) |=> offReg[k] == $past(inData));
    // R8: gain calibration captures the dedicated gain word
    p_gain_capture_r8: assert property (@(posedge clk) disable iff (!rstN)
      (st.gainLoad[k] && st.gainFromCal) |=> gainReg[k] == $past(gainCalIn));
    // R2: unselected registers keep their value
    p_pair_stable_r2: assert property (@(posedge clk) disable iff (!rstN)
      (!st.offLoad[k] && !st.gainLoad[k]) |=> ($stable(offReg[k]) && $stable(gainReg[k])));
  end

  // Readback
  always_comb begin
    regRdData = '0;
    if (st.rdOff)       regRdData = offReg[st.pairIdx];
    else if (st.rdGain) regRdData = gainReg[st.pairIdx];
  end

  // Pair selection for the conversion path
  logic [DW-1:0] selOff, selGain;
  always_comb begin
    selOff  = '0;
    selGain = UNITY;
    if (st.pairHit) begin
      selOff  = offReg[st.pairIdx];
      selGain = gainReg[st.pairIdx];
    end
  end

  // Stage 1: offset subtraction
  logic                 s1Valid;
  logic signed [DW:0]   s1Diff;
  logic [DW-1:0]        s1Gain;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Diff  <= '0;
      s1Gain  <= '0;
    end else begin
      s1Valid <= st.convStart;
      if (st.convStart) begin
        s1Diff <= $signed({inData[DW-1], inData}) - $signed({selOff[DW-1], selOff});
        s1Gain <= selGain;
      end
    end
  end

  // Stage 2: gain scaling with saturation
  logic signed [PW-1:0] diffX, gainX, prod, scaled;
  logic [DW-1:0]        satVal;
  always_comb begin
    diffX  = PW'(s1Diff);
    gainX  = $signed(PW'({1'b0, s1Gain}));
    prod   = diffX * gainX;
    scaled = prod >>> FRAC;
    if (scaled > MAXV)      satVal = MAXV[DW-1:0];
    else if (scaled < MINV) satVal = MINV[DW-1:0];
    else                    satVal = scaled[DW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outData  <= '0;
    end else begin
      outValid <= s1Valid;
      if (s1Valid) outData <= satVal;
    end
  end

  // R6: fixed two-stage latency and hold between results
  p_stage1_r6: assert property (@(posedge clk) disable iff (!rstN)
    st.convStart |=> s1Valid);
  p_latency_r6: assert property (@(posedge clk) disable iff (!rstN)
    s1Valid |=> outValid);
  p_no_spurious_r6: assert property (@(posedge clk) disable iff (!rstN)
    !s1Valid |=> (!outValid && $stable(outData)));
endmodule

// File: rtl/calCorrector.sv
module calCorrector
  import calPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [CAL_DW-1:0]  inData,
  input  logic [2:0]         modeCode,
  input  logic [CAL_CHW-1:0] chanSel,
  input  logic [CAL_DW-1:0]  gainCalIn,
  input  logic               regWrEn,
  input  logic [2:0]         regSel,
  input  logic [CAL_DW-1:0]  regWrData,
  output logic [CAL_DW-1:0]  regRdData,
  output logic               outValid,
  output logic [CAL_DW-1:0]  outData
);
  calStrobes_t st;

  calCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .modeCode(modeCode),
    .chanSel(chanSel), .regWrEn(regWrEn), .regSel(regSel), .st(st)
  );

  calDatapath u_dp (
    .clk(clk), .rstN(rstN), .st(st), .inData(inData), .gainCalIn(gainCalIn),
    .regWrData(regWrData), .regRdData(regRdData), .outValid(outValid),
    .outData(outData)
  );
endmodule

// File: tb/tb_calCorrector.sv
module tb_calCorrector;
  logic clk = 0, rstN = 0;
  logic inValid = 0, regWrEn = 0;
  logic [23:0] inData = 0, gainCalIn = 0, regWrData = 0;
  logic [2:0]  modeCode = 0, regSel = 0;
  logic [1:0]  chanSel = 0;
  logic [23:0] regRdData, outData;
  logic        outValid;

  always #2 clk = ~clk;

  calCorrector dut (.*);

  int checks = 0, failures = 0;
  bit done = 0;
  logic [23:0] mOff [3];
  logic [23:0] mGain [3];
  bit h1v = 0, h2v = 0;
  logic [23:0] h1d = 0, h2d = 0;
  string h1t = "R4", h2t = "R4";

  task automatic chk(bit ok, string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [23:0] correct(logic [23:0] d, logic [23:0] o, logic [23:0] g);
    longint diff, p;
    diff = longint'($signed(d)) - longint'($signed(o));
    p = (diff * longint'({40'd0, g})) >>> 23;
    if (p > 64'sd8388607) return 24'h7FFFFF;
    if (p < -64'sd8388608) return 24'h800000;
    return p[23:0];
  endfunction

  function automatic logic [23:0] modelRead(logic [2:0] s, logic [1:0] c);
    if (c == 2'd3) return 0;
    if (s == 3'b101) return mOff[c];
    if (s == 3'b110) return mGain[c];
    return 0;
  endfunction

  task automatic step(bit v, logic [2:0] md, logic [1:0] ch, logic [23:0] din,
                      logic [23:0] gc, bit we, logic [2:0] sel, logic [23:0] wd,
                      string rtag, string otag);
    bit conv;
    logic [23:0] e;
    @(negedge clk);
    chk(outValid == h2v, "R6", 24'(outValid), 24'(h2v));
    if (h2v) chk(outData == h2d, h2t, outData, h2d);
    inValid = v; modeCode = md; chanSel = ch; inData = din; gainCalIn = gc;
    regWrEn = we; regSel = sel; regWrData = wd;
    #1;
    chk(regRdData == modelRead(sel, ch), rtag, regRdData, modelRead(sel, ch));
    conv = v && !md[2];
    e = (ch == 2'd3) ? correct(din, 24'd0, 24'h800000) : correct(din, mOff[ch], mGain[ch]);
    h2v = h1v; h2d = h1d; h2t = h1t;
    h1v = conv; h1d = e; h1t = otag;
    if (ch != 2'd3) begin
      if (we && sel == 3'b101) mOff[ch] = wd;
      if (we && sel == 3'b110) mGain[ch] = wd;
      if (v && md[2] && !md[0]) mOff[ch] = din;
      if (v && md[2] && md[0]) mGain[ch] = gc;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(0, 3'b000, 2'd0, 0, 0, 0, 3'b000, 0, "R3", "R4");
  endtask

  task automatic wr(logic [2:0] sel, logic [1:0] ch, logic [23:0] d);
    step(0, 3'b000, ch, 0, 0, 1, sel, d, "R2", "R4");
  endtask

  task automatic conv(logic [1:0] ch, logic [23:0] d, string tag);
    step(1, 3'b000, ch, d, 0, 0, 3'b101, 0, "R2", tag);
  endtask

  initial begin
    #400000;
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 24'd0, 24'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 3; k++) begin mOff[k] = 0; mGain[k] = 24'h800000; end
    repeat (4) @(negedge clk);
    // R1: reset state seen during reset
    chk(outValid == 0, "R1", 24'(outValid), 0);
    rstN = 1;
    for (int k = 0; k < 3; k++) begin
      step(0, 0, 2'(k), 0, 0, 0, 3'b101, 0, "R1", "R4");
      step(0, 0, 2'(k), 0, 0, 0, 3'b110, 0, "R1", "R4");
    end
    // R2 / R4: unity gain, zero offset passes through
    conv(2'd0, 24'h123456, "R4");
    // R4: order of operations: (0x300-0x100)*0.5 = 0x100
    wr(3'b101, 2'd1, 24'h000100);
    wr(3'b110, 2'd1, 24'h400000);
    conv(2'd1, 24'h000300, "R4");
    // R5: positive and negative clamp
    wr(3'b101, 2'd2, 24'h800000);
    conv(2'd2, 24'h7FFFFF, "R5");
    wr(3'b101, 2'd2, 24'h7FFFFF);
    conv(2'd2, 24'h800000, "R5");
    // R4: zero gain gives zero
    wr(3'b110, 2'd0, 24'h000000);
    conv(2'd0, 24'h654321, "R4");
    // R3: unknown register code ignored, reads zero
    step(0, 0, 2'd0, 0, 0, 1, 3'b011, 24'hABCDEF, "R3", "R4");
    step(0, 0, 2'd0, 0, 0, 0, 3'b011, 0, "R3", "R4");
    // R7: offset calibration with competing write on same register
    step(1, 3'b110, 2'd1, 24'h000777, 0, 1, 3'b101, 24'h111111, "R2", "R4");
    step(0, 0, 2'd1, 0, 0, 0, 3'b101, 0, "R7", "R4");
    // R8: gain calibration with competing write
    step(1, 3'b101, 2'd1, 24'h0, 24'h600000, 1, 3'b110, 24'h222222, "R2", "R4");
    step(0, 0, 2'd1, 0, 0, 0, 3'b110, 0, "R8", "R4");
    step(1, 3'b111, 2'd0, 24'h0, 24'h900000, 0, 3'b110, 0, "R2", "R4");
    step(0, 0, 2'd0, 0, 0, 0, 3'b110, 0, "R8", "R4");
    step(1, 3'b100, 2'd0, 24'hFFF000, 0, 0, 3'b101, 0, "R2", "R4");
    step(0, 0, 2'd0, 0, 0, 0, 3'b101, 0, "R7", "R4");
    conv(2'd1, 24'h100777, "R4");
    // R9: channel 3 ignored and passes through
    step(0, 0, 2'd3, 0, 0, 1, 3'b101, 24'h555555, "R9", "R4");
    step(1, 3'b100, 2'd3, 24'h333333, 0, 0, 3'b110, 0, "R9", "R4");
    conv(2'd3, 24'h876543, "R9");
    idle(3);
    // random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] md, sel;
      logic [1:0] ch;
      bit v, we;
      v   = ($urandom % 3) != 0;
      md  = ($urandom % 4 == 0) ? 3'(3'b100 | 3'($urandom % 4)) : 3'($urandom % 4);
      ch  = 2'($urandom % 4);
      we  = ($urandom % 5) == 0;
      sel = ($urandom % 4 == 0) ? 3'($urandom) : (($urandom % 2) ? 3'b101 : 3'b110);
      step(v, md, ch, 24'($urandom), 24'($urandom), we, sel, 24'($urandom), "R2", "R4");
    end
    idle(3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule